// File: doc/BRIEF.md
# Clock Source Command/Status Controller

This block holds the clock settings that software asks for and reports the settings that are really in effect. Software writes one byte to a command register. The byte names a low-speed oscillator, a main oscillator, a speed for the timer tick and a speed for the system clock. The block treats each source choice as a request. A request completes only when the matching ready input pulses, and the switch of the low-speed source has an extra precondition.

Each speed is a power-of-two division of a fast reference. While the 16 MHz RC source is active, neither speed may exceed the rate that source can supply. The status register shows the clamped speeds and the source bits that are actually active.

The block also produces two clock-enable strobes, one for the system clock and one for the timer tick. Both come from one free-running divide counter that runs at the reference rate. The counter stands in for real clock gating.

Top module: `clk_src_ctrl`

## Requirements
- R1: The command register sits at address 0 and reads back the last byte written to it. Its fields are: bit 7 = low-speed source (1 = RC, 0 = crystal); bit 6 = main source (1 = 16 MHz RC, 0 = 32 MHz crystal); bits 5:3 = tick speed code; bits 2:0 = system speed code.
- R2: After reset, the command register and the status register (address 1, same layout) both read 0xC9.
- R3: An effective speed code n gives a strobe once every 2^n reference cycles. This holds separately for the system strobe and the tick strobe.
- R4: While the active main source is RC, a speed code of 000 is reported as 001 in the status register and runs at 001. The two speed fields are clamped independently, and any other code passes through unchanged.
- R5: The status main-source bit changes only in a cycle where main_ready is high. It then takes the requested value.
- R6: The status low-source bit takes the requested value only in a cycle where low_ready is high and the active main source is RC. Otherwise the request stays pending and low_ready has no effect.
- R7: Clamping always follows the active main source. After a completed switch to the crystal, a code of 000 is reported as 000.
- R8: While the applied system code is 000, sys_stb is high on every cycle.
- R9: A change of the effective code takes effect only at a wrap of the divide counter. Every gap between strobes is therefore either the old period or the new period.
- R10: The status register is read-only. A write to address 1 changes neither register.
- R11: Reads of addresses other than 0 and 1 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (32 MHz rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (2) | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| main_ready | input | 1 | One-cycle pulse: the requested main oscillator is stable |
| low_ready | input | 1 | One-cycle pulse: the requested low-speed oscillator is stable |
| sys_stb | output | 1 | System clock enable |
| tick_stb | output | 1 | Timer tick enable |

## Verification
Register reads are combinational. A write or a ready pulse therefore shows in rd_data in the cycle after the edge that captured it. The scoreboard sets the address just after an edge and compares at the following falling edge.

A new speed code reaches the strobes only at the next counter wrap, which can be up to 128 cycles later. The strobe checks therefore wait more than one full wrap before they measure a period.

The realignment check is different: it records every gap across the change. It accepts only the old period or the new one.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = (1 << CODE_W) - 1;

    typedef struct packed {
        logic              low_rc;
        logic              main_rc;
        logic [CODE_W-1:0] tick;
        logic [CODE_W-1:0] sys;
    } clk_word_t;

    localparam clk_word_t CLK_WORD_RST = '{low_rc: 1'b1, main_rc: 1'b1,
                                           tick: CODE_W'(1), sys: CODE_W'(1)};

    typedef enum logic [1:0] {
        ADDR_CMD  = 2'd0,
        ADDR_STAT = 2'd1
    } reg_addr_e;

    function automatic logic [CODE_W-1:0] clamp_code(input logic main_rc,
                                                     input logic [CODE_W-1:0] code);
        return (main_rc && code == '0) ? CODE_W'(1) : code;
    endfunction
endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
    import clk_src_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    input  logic          main_ready,
    input  logic          low_ready,
    output clk_word_t     cmd,
    output clk_word_t     sts,
    output logic [7:0]    rd_data
);
    logic main_act, low_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= CLK_WORD_RST;
            main_act <= 1'b1;
            low_act  <= 1'b1;
        end else begin
            if (wr_en && addr == AW'(ADDR_CMD))
                cmd <= clk_word_t'(wr_data);
            if (main_ready && cmd.main_rc != main_act)
                main_act <= cmd.main_rc;
            if (low_ready && main_act && cmd.low_rc != low_act)
                low_act <= cmd.low_rc;
        end
    end

    always_comb begin
        sts.low_rc  = low_act;
        sts.main_rc = main_act;
        sts.tick    = clamp_code(main_act, cmd.tick);
        sts.sys     = clamp_code(main_act, cmd.sys);
    end

    always_comb begin
        if (addr == AW'(ADDR_CMD))       rd_data = cmd;
        else if (addr == AW'(ADDR_STAT)) rd_data = sts;
        else                             rd_data = '0;
    end
endmodule

// File: rtl/clk_div_count.sv
module clk_div_count
    import clk_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign wrap = &cnt;
endmodule

// File: rtl/clk_stb_gen.sv
module clk_stb_gen
    import clk_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_eff,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    output logic [CODE_W-1:0] applied,
    output logic              stb
);
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst)       applied <= CODE_W'(1);
        else if (wrap) applied <= code_eff;
    end

    always_comb begin
        mask = ~({CNT_W{1'b1}} << applied);
        stb  = (cnt & mask) == '0;
    end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          main_ready,
    input  logic          low_ready,
    output logic          sys_stb,
    output logic          tick_stb
);
    localparam int N_STB = 2;

    clk_word_t         cmd, sts;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [CODE_W-1:0] codes   [N_STB];
    logic [CODE_W-1:0] applied [N_STB];
    logic [N_STB-1:0]  stbs;

    clk_src_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .main_ready(main_ready), .low_ready(low_ready),
        .cmd(cmd), .sts(sts), .rd_data(rd_data)
    );

    clk_div_count u_cnt (.clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap));

    assign codes[0] = sts.sys;
    assign codes[1] = sts.tick;

    for (genvar i = 0; i < N_STB; i++) begin : g_stb
        clk_stb_gen u_gen (
            .clk(clk), .rst(rst), .code_eff(codes[i]), .cnt(cnt), .wrap(wrap),
            .applied(applied[i]), .stb(stbs[i])
        );
    end

    assign sys_stb  = stbs[0];
    assign tick_stb = stbs[1];
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk
    import clk_src_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input clk_word_t         cmd,
    input clk_word_t         sts,
    input logic              main_ready,
    input logic              low_ready,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] app_sys,
    input logic              sys_stb
);
    // R2
    a_r2_reset_cmd: assert property (@(posedge clk) rst |=> cmd == CLK_WORD_RST);
    // R4
    a_r4_clamp_sys: assert property (@(posedge clk) disable iff (rst)
        sts.main_rc |-> sts.sys != '0 && sts.tick != '0);
    // R5
    a_r5_main_hold: assert property (@(posedge clk) disable iff (rst)
        !main_ready |=> $stable(sts.main_rc));
    // R6
    a_r6_low_gate: assert property (@(posedge clk) disable iff (rst)
        !(low_ready && sts.main_rc) |=> $stable(sts.low_rc));
    // R8
    a_r8_full_rate: assert property (@(posedge clk) disable iff (rst)
        app_sys == '0 |-> sys_stb);
    // R9
    a_r9_realign: assert property (@(posedge clk) disable iff (rst)
        !$stable(app_sys) |-> cnt == '0);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cmd(cmd), .sts(sts), .main_ready(main_ready),
    .low_ready(low_ready), .cnt(cnt), .app_sys(applied[0]), .sys_stb(sys_stb)
);

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       main_ready = 1'b0;
    logic       low_ready = 1'b0;
    logic       sys_stb, tick_stb;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    clk_src_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .main_ready(main_ready), .low_ready(low_ready),
        .sys_stb(sys_stb), .tick_stb(tick_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(rd_data == it.exp, it.tag, rd_data, it.exp);
        end
    end

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse_main();
        @(posedge clk); #1; main_ready = 1'b1;
        @(posedge clk); #1; main_ready = 1'b0;
    endtask

    task automatic pulse_low();
        @(posedge clk); #1; low_ready = 1'b1;
        @(posedge clk); #1; low_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic gap(input bit use_tick, output int g);
        do @(negedge clk); while (!(use_tick ? tick_stb : sys_stb));
        g = 0;
        do begin @(negedge clk); g++; end while (!(use_tick ? tick_stb : sys_stb));
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int g;
        bit ok;
        idle(3); #1; rst = 1'b0;
        expect_rd(2'd0, 8'hC9, "R2 cmd reset");
        expect_rd(2'd1, 8'hC9, "R2 status reset");
        expect_rd(2'd2, 8'h00, "R11 addr 2");
        expect_rd(2'd3, 8'h00, "R11 addr 3");

        wr(2'd0, 8'hC0);
        expect_rd(2'd0, 8'hC0, "R1 cmd readback");
        expect_rd(2'd1, 8'hC9, "R4 both codes clamped to 001");

        wr(2'd0, 8'h80);
        idle(5);
        expect_rd(2'd1, 8'hC9, "R5 main pending without ready");
        pulse_low();
        expect_rd(2'd1, 8'hC9, "R5 low_ready does not move main");
        pulse_main();
        expect_rd(2'd1, 8'h80, "R7 crystal active, codes unclamped");
        idle(140);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sys_stb) ok = 1'b0;
        end
        check(ok, "R8 sys strobe every cycle", ok, 1);
        gap(1'b1, g);
        check(g == 1, "R3 tick code 0 gap", g, 1);

        wr(2'd0, 8'h00);
        pulse_low();
        expect_rd(2'd1, 8'h80, "R6 low switch blocked on crystal");
        wr(2'd0, 8'h40);
        pulse_main();
        expect_rd(2'd1, 8'hC9, "R6 low still pending after main switch");
        pulse_low();
        expect_rd(2'd1, 8'h49, "R6 low switch done on RC");

        wr(2'd1, 8'hFF);
        expect_rd(2'd1, 8'h49, "R10 status write ignored");
        expect_rd(2'd0, 8'h40, "R10 cmd untouched");

        wr(2'd0, 8'h6B);
        expect_rd(2'd1, 8'h6B, "R4 nonzero codes pass");
        idle(140);
        gap(1'b0, g);
        check(g == 8, "R3 sys code 3 period", g, 8);
        gap(1'b1, g);
        check(g == 32, "R3 tick code 5 period", g, 32);

        wr(2'd0, 8'h42);
        expect_rd(2'd1, 8'h4A, "R4 fields clamped independently");
        idle(140);
        gap(1'b0, g);
        check(g == 4, "R3 sys code 2 period", g, 4);
        gap(1'b1, g);
        check(g == 2, "R4 tick runs at clamped code 1", g, 2);

        wr(2'd0, 8'h47);
        idle(300);
        wr(2'd0, 8'h42);
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            gap(1'b0, g);
            if (g != 128 && g != 4) ok = 1'b0;
        end
        check(ok, "R9 no runt gap across code change", g, 4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule